// File: doc/BRIEF.md
# Timed Boot-Entry Unlock Guard

This block decides whether a CPU's jump-to-boot instruction may actually enter the boot ROM. Software first stores an unlock code into a memory-mapped register. When the upper six bits of the stored byte equal the expected code, an unlock flag rises. The flag then stays up for a fixed number of instruction cycles and drops by itself. A jump-to-boot request reaches the boot ROM only while the flag is up. At any other time the same request falls through to the flash address that the instruction encodes. Runaway code that hits the jump opcode by accident therefore cannot leave flash.

The unlock window is counted in instruction cycles. A one-clock tick input marks each instruction cycle, so the window is independent of the clock ratio. While an emulation breakpoint holds the core, the count freezes. A successful boot entry uses up the unlock at once. A fresh matching store restarts the window at its full length.

Top module: `bootkey_guard`

## Requirements
- R1: A clock edge with `wr_en` high and `wr_data[7:2]` equal to binary 100110 sets `key_flag` after that edge. `wr_data[1:0]` have no effect on the match. A code value on `wr_data` while `wr_en` is low does nothing.
- R2: After a matching store, `key_flag` stays high through exactly 8 counted instruction ticks. It goes low at the clock edge that samples the 8th tick.
- R3: A store whose upper six bits differ from 100110 leaves `key_flag` unchanged, whether the flag is clear or already set.
- R4: While `key_flag` is high, `jmp_req` raises `boot_sel` combinationally in the same cycle. `boot_sel` high means the boot ROM target.
- R5: While `key_flag` is low, `boot_sel` stays low even with `jmp_req` high. `boot_sel` low means the flash target.
- R6: While `brk_hold` is high, ticks are not counted. The remaining window resumes once `brk_hold` goes low.
- R7: A matching store made while `key_flag` is already high reloads the window to a full 8 ticks.
- R8: A jump taken to boot ROM clears `key_flag` at that edge, so only one jump is allowed per unlock. A matching store in the same cycle takes priority and leaves the flag set.
- R9: Synchronous active-high `rst` clears `key_flag` and the tick count. Reset overrides every other input.
- R10: Only clock edges with `cyc_tick` high advance the window. Clock edges without a tick leave `key_flag` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Unlock register store strobe |
| wr_data | input | 8 | Byte stored to the unlock register |
| cyc_tick | input | 1 | One-clock pulse per instruction cycle |
| brk_hold | input | 1 | Emulation breakpoint active; freezes the window |
| jmp_req | input | 1 | Jump-to-boot instruction being executed |
| key_flag | output | 1 | Unlock window open |
| boot_sel | output | 1 | Jump target: 1 = boot ROM, 0 = flash |

## Verification
The stored byte is tested with the exact code, with the code plus both ignored low bits set, with a code that differs only in the lowest key bit, with one that differs only in the top bit, and with the code on the bus while the strobe is low. Together these separate a correct six-bit comparison from a comparison that is too wide, too narrow or missing the strobe. The window is counted through plain ticks, through idle clocks with no tick, and through ticks masked by a breakpoint. These patterns tell an off-by-one limit, a per-clock count and an ignored freeze apart. Jumps are issued with the flag clear, with the flag set, straight after a taken jump, and in the same cycle as a reload. These cases expose a missing consume and a wrong priority between a store and a jump.

// File: rtl/bootkey_pkg.sv
package bootkey_pkg;

    localparam int unsigned DATA_W     = 8;
    localparam int unsigned KEY_W      = 6;
    localparam logic [KEY_W-1:0] KEY_CODE = 6'b100110;
    localparam int unsigned WINDOW_CYC = 8;

    typedef enum logic {
        TGT_FLASH = 1'b0,
        TGT_BOOT  = 1'b1
    } target_e;

endpackage

// File: rtl/bootkey_match.sv
module bootkey_match
    import bootkey_pkg::*;
#(
    parameter int unsigned DW = DATA_W,
    parameter int unsigned KW = KEY_W,
    parameter logic [KW-1:0] CODE = KEY_CODE
) (
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic          load
);
    localparam int unsigned IGN_W = DW - KW;
    localparam logic [DW-1:0] MASK    = {{KW{1'b1}}, {IGN_W{1'b0}}};
    localparam logic [DW-1:0] PATTERN = {CODE, {IGN_W{1'b0}}};

    logic hit;

    always_comb begin
        // compare the upper key field only; the low bits are masked off
        hit  = ((wr_data & MASK) == PATTERN);
        load = wr_en && hit;
    end

endmodule

// File: rtl/bootkey_window.sv
module bootkey_window
    import bootkey_pkg::*;
#(
    parameter int unsigned WINDOW = WINDOW_CYC
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic consume,
    input  logic tick,
    input  logic hold,
    output logic flag
);
    localparam int unsigned CNT_W = $clog2(WINDOW + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(WINDOW);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

    typedef struct packed {
        logic             flag;
        logic [CNT_W-1:0] cnt;
    } win_state_t;

    win_state_t st_d, st_q;
    logic       step;

    always_comb begin
        st_d = st_q;
        step = tick && !hold && st_q.flag;
        if (load) begin
            st_d.flag = 1'b1;
            st_d.cnt  = FULL;
        end else if (consume) begin
            st_d.flag = 1'b0;
            st_d.cnt  = '0;
        end else if (step) begin
            st_d.cnt = st_q.cnt - LAST;
            if (st_q.cnt == LAST) begin
                st_d.flag = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag = st_q.flag;

    a_r2_flag_has_count: assert property (@(posedge clk) disable iff (rst)
        st_q.flag |-> (st_q.cnt != '0));

    a_r7_load_fills: assert property (@(posedge clk) disable iff (rst)
        load |=> (st_q.flag && st_q.cnt == FULL));

    a_r6_freeze: assert property (@(posedge clk) disable iff (rst)
        (hold && !load && !consume) |=> ($stable(st_q.cnt) && $stable(st_q.flag)));

    a_r10_no_tick_no_change: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load && !consume) |=> ($stable(st_q.cnt) && $stable(st_q.flag)));

endmodule

// File: rtl/bootkey_route.sv
module bootkey_route
    import bootkey_pkg::*;
(
    input  logic jmp_req,
    input  logic unlocked,
    output logic boot_sel,
    output logic consume
);
    target_e tgt;

    always_comb begin
        tgt      = unlocked ? TGT_BOOT : TGT_FLASH;
        boot_sel = jmp_req && (tgt == TGT_BOOT);
        consume  = boot_sel;
    end

endmodule

// File: rtl/bootkey_guard.sv
module bootkey_guard
    import bootkey_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cyc_tick,
    input  logic              brk_hold,
    input  logic              jmp_req,
    output logic              key_flag,
    output logic              boot_sel
);
    logic load;
    logic consume;

    bootkey_match #(
        .DW   (DATA_W),
        .KW   (KEY_W),
        .CODE (KEY_CODE)
    ) i_match (
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .load    (load)
    );

    bootkey_window #(
        .WINDOW (WINDOW_CYC)
    ) i_window (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .consume (consume),
        .tick    (cyc_tick),
        .hold    (brk_hold),
        .flag    (key_flag)
    );

    bootkey_route i_route (
        .jmp_req  (jmp_req),
        .unlocked (key_flag),
        .boot_sel (boot_sel),
        .consume  (consume)
    );

    a_r4_boot_needs_key: assert property (@(posedge clk) disable iff (rst)
        boot_sel |-> key_flag);

    a_r5_locked_goes_flash: assert property (@(posedge clk) disable iff (rst)
        (jmp_req && !key_flag) |-> !boot_sel);

    a_r8_jump_consumes: assert property (@(posedge clk) disable iff (rst)
        (boot_sel && !load) |=> !key_flag);

    a_r9_reset_clears: assert property (@(posedge clk)
        rst |=> !key_flag);

    a_r3_rise_needs_load: assert property (@(posedge clk) disable iff (rst)
        $rose(key_flag) |-> $past(load));

endmodule

// File: tb/test_bootkey_guard.sv
module test_bootkey_guard;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 52;
    localparam int WATCHDOG = 5000;

    // vector: {wr, data[7:0], tick, brk, jmp, exp_boot, exp_key}
    localparam logic [13:0] VEC [NVEC] = '{
        {1'b1, 8'h98, 3'b000, 2'b01},  // 0  R1 exact code
        {1'b0, 8'h00, 3'b100, 2'b01},  // 1  R2
        {1'b0, 8'h00, 3'b100, 2'b01},
        {1'b0, 8'h00, 3'b100, 2'b01},
        {1'b0, 8'h00, 3'b100, 2'b01},
        {1'b0, 8'h00, 3'b100, 2'b01},
        {1'b0, 8'h00, 3'b100, 2'b01},
        {1'b0, 8'h00, 3'b100, 2'b01},  // 7  R2 seventh tick
        {1'b0, 8'h00, 3'b100, 2'b00},  // 8  R2 eighth tick clears
        {1'b0, 8'h00, 3'b001, 2'b00},  // 9  R5 locked jump
        {1'b1, 8'h9B, 3'b000, 2'b01},  // 10 R1 low bits ignored
        {1'b0, 8'h00, 3'b100, 2'b01},  // 11
        {1'b0, 8'h00, 3'b110, 2'b01},  // 12 R6 frozen
        {1'b0, 8'h00, 3'b110, 2'b01},  // 13 R6 frozen
        {1'b0, 8'h00, 3'b100, 2'b01},  // 14
        {1'b0, 8'h00, 3'b100, 2'b01},
        {1'b0, 8'h00, 3'b100, 2'b01},
        {1'b0, 8'h00, 3'b100, 2'b01},
        {1'b0, 8'h00, 3'b100, 2'b01},
        {1'b0, 8'h00, 3'b100, 2'b01},  // 19 R6 still open
        {1'b0, 8'h00, 3'b100, 2'b00},  // 20 R6 resumed, closes
        {1'b1, 8'h9C, 3'b000, 2'b00},  // 21 R3 low key bit wrong
        {1'b1, 8'h18, 3'b000, 2'b00},  // 22 R3 top bit wrong
        {1'b1, 8'h98, 3'b000, 2'b01},  // 23
        {1'b0, 8'h00, 3'b000, 2'b01},  // 24 R10 idle clock
        {1'b0, 8'h00, 3'b000, 2'b01},  // 25 R10 idle clock
        {1'b0, 8'h00, 3'b100, 2'b01},  // 26
        {1'b0, 8'h00, 3'b100, 2'b01},
        {1'b0, 8'h00, 3'b100, 2'b01},
        {1'b0, 8'h00, 3'b100, 2'b01},
        {1'b0, 8'h00, 3'b100, 2'b01},  // 30 three left
        {1'b1, 8'h98, 3'b000, 2'b01},  // 31 R7 reload
        {1'b0, 8'h00, 3'b100, 2'b01},  // 32
        {1'b0, 8'h00, 3'b100, 2'b01},
        {1'b0, 8'h00, 3'b100, 2'b01},
        {1'b0, 8'h00, 3'b100, 2'b01},
        {1'b0, 8'h00, 3'b100, 2'b01},
        {1'b0, 8'h00, 3'b100, 2'b01},
        {1'b0, 8'h00, 3'b100, 2'b01},  // 38 R7 seventh tick after reload
        {1'b0, 8'h00, 3'b100, 2'b00},  // 39 R7 eighth closes
        {1'b1, 8'h98, 3'b000, 2'b01},  // 40
        {1'b0, 8'h00, 3'b001, 2'b10},  // 41 R4 boot jump, R8 consumed
        {1'b0, 8'h00, 3'b001, 2'b00},  // 42 R8 second jump to flash
        {1'b1, 8'h98, 3'b000, 2'b01},  // 43
        {1'b1, 8'h54, 3'b000, 2'b01},  // 44 R3 mismatch while open
        {1'b0, 8'h00, 3'b001, 2'b10},  // 45 R4
        {1'b0, 8'h98, 3'b000, 2'b00},  // 46 R1 no strobe
        {1'b0, 8'h00, 3'b100, 2'b00},  // 47 R10 tick while closed
        {1'b0, 8'h00, 3'b010, 2'b00},  // 48 R6 breakpoint while closed
        {1'b1, 8'h98, 3'b000, 2'b01},  // 49
        {1'b1, 8'h98, 3'b001, 2'b11},  // 50 R8 store beats consume
        {1'b0, 8'h00, 3'b001, 2'b10}   // 51 R8 window still usable once
    };

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic [7:0] wr_data;
    logic       cyc_tick;
    logic       brk_hold;
    logic       jmp_req;
    logic       key_flag;
    logic       boot_sel;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bootkey_guard i_bootkey_guard (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .cyc_tick (cyc_tick),
        .brk_hold (brk_hold),
        .jmp_req  (jmp_req),
        .key_flag (key_flag),
        .boot_sel (boot_sel)
    );

    task automatic check(input string req, input logic act, input logic exp, input int idx);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s step %0d actual=%b expected=%b", req, idx, act, exp);
        end
    endtask

    task automatic idle_inputs();
        wr_en = 1'b0; wr_data = 8'h00; cyc_tick = 1'b0; brk_hold = 1'b0; jmp_req = 1'b0;
    endtask

    task automatic step(input logic w, input logic [7:0] d, input logic t, input logic b, input logic j);
        @(negedge clk);
        wr_en = w; wr_data = d; cyc_tick = t; brk_hold = b; jmp_req = j;
        #1;
    endtask

    initial begin
        rst = 1'b1;
        idle_inputs();
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 reset key", key_flag, 1'b0, -1);
        check("R9 reset boot", boot_sel, 1'b0, -1);
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][13], VEC[i][12:5], VEC[i][4], VEC[i][3], VEC[i][2]);
            check("boot_sel R4/R5/R8", boot_sel, VEC[i][1], i);
            @(posedge clk);
            #1;
            check("key_flag R1/R2/R3/R6/R7/R8/R10", key_flag, VEC[i][0], i);
        end

        // R9: reset mid-window closes it, even with a store pending
        step(1'b1, 8'h98, 1'b0, 1'b0, 1'b0);
        @(posedge clk); #1;
        check("R9 pre-reset open", key_flag, 1'b1, 100);
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b1; wr_data = 8'h98;
        @(posedge clk); #1;
        check("R9 reset beats store", key_flag, 1'b0, 101);
        @(negedge clk);
        rst = 1'b0; idle_inputs(); jmp_req = 1'b1;
        #1;
        check("R9 jump after reset to flash", boot_sel, 1'b0, 102);

        // R2/R6: long breakpoint keeps window open across many ticks
        step(1'b1, 8'h98, 1'b0, 1'b0, 1'b0);
        @(posedge clk); #1;
        for (int k = 0; k < 20; k++) begin
            step(1'b0, 8'h00, 1'b1, 1'b1, 1'b0);
            @(posedge clk); #1;
        end
        check("R6 open after long freeze", key_flag, 1'b1, 103);
        for (int k = 0; k < 7; k++) begin
            step(1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
            @(posedge clk); #1;
        end
        check("R2 open after 7 ticks", key_flag, 1'b1, 104);
        step(1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
        @(posedge clk); #1;
        check("R2 closed after 8 ticks", key_flag, 1'b0, 105);

        idle_inputs();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule